// File: doc/BRIEF.md
# Lifetime Compensation PWM Scheduler

This block drives the compensation input of a lamp driver with a slow 8-bit pulse-width signal. The duty cycle depends on how long the lamp has been in service. Lamps of this kind lose brightness as they age. A narrower pulse on the compensation input makes the driver push harder, so the width is stepped down as service time grows. The result is that the perceived brightness stays roughly constant over the life of the lamp.

A separate time-keeping block supplies the service age as a count of whole hundreds of hours. Each hundred-hour span selects one pulse width from a fixed schedule. The schedule runs from about 45% duty on a new lamp down to about 15% once the lamp is past one thousand hours, and it holds there from then on. A clock prescaler sets how many system clocks make up one PWM count. A new width is adopted only when a PWM period wraps, so no period is ever cut short or stretched.

Top module: `life_comp_pwm`

## Requirements
- R1: One PWM period is 255 counts (count values 0 to 254). The output is high during the first W counts of each period and low for the rest, where W is the active width.
- R2: The width for each hundred-hour band index 0,1,...,10 is, in that order, 115, 108, 100, 92, 85, 77, 69, 61, 54, 46, 38.
- R3: The band index equals the age input (hundreds of hours) clamped to 10, so every age of 10 or more yields width 38.
- R4: As the band index rises, the width falls strictly, so duty only drops as the lamp ages.
- R5: A width change caused by the age input takes effect only at the wrap from count 254 to count 0. A period already in progress finishes with the width it started with.
- R6: Reset is synchronous and active low. While it is asserted the output is low and the band 0 width (115) is loaded, so the first period after release uses 115 whatever the age input.
- R7: The PWM count advances once every TICK_DIV clocks. One period therefore lasts 255*TICK_DIV clocks, and the output stays high for W*TICK_DIV of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_n_i | input | 1 | Synchronous active-low reset |
| life_hundreds_i | input | HOURS_W | Lamp service age in hundreds of hours |
| pwm_o | output | 1 | Compensation PWM to the lamp driver |

## Verification
The bench builds two copies of the block. The main copy uses TICK_DIV=1, so one period is exactly 255 clocks. This lets every band width be measured as a count of high cycles within one aligned period, and it lets the check land on the exact period where a mid-period age change either must not act or must act. HOURS_W is set to 5 so that ages up to 31 are reachable and the clamp above band 10 is exercised. A second copy with TICK_DIV=3 shares the age input and confirms that the prescaler stretches both the period length and the high time by the division factor.

// File: rtl/life_comp_pkg.sv
// Package: shared constants and the band-to-width schedule for the
// lifetime compensation PWM. Assumes a fixed eleven-band schedule.
package life_comp_pkg;

    localparam int NUM_BANDS = 11;
    localparam int LAST_BAND = NUM_BANDS - 1;
    localparam int BAND_W    = $clog2(NUM_BANDS);
    localparam int WIDTH_W   = 8;

    typedef logic [BAND_W-1:0]  band_t;
    typedef logic [WIDTH_W-1:0] width_t;

    // Pulse width (in counts of a 255-count period) for each age band.
    function automatic width_t band_width(input band_t idx);
        width_t w;
        case (idx)
            4'd0:    w = 8'd115;
            4'd1:    w = 8'd108;
            4'd2:    w = 8'd100;
            4'd3:    w = 8'd92;
            4'd4:    w = 8'd85;
            4'd5:    w = 8'd77;
            4'd6:    w = 8'd69;
            4'd7:    w = 8'd61;
            4'd8:    w = 8'd54;
            4'd9:    w = 8'd46;
            default: w = 8'd38;
        endcase
        return w;
    endfunction

endpackage

// File: rtl/lc_band_select.sv
// Module: maps the service age (hundreds of hours) to a band index.
// Assumes: ages beyond the last band saturate at the last band.
module lc_band_select
    import life_comp_pkg::*;
#(
    parameter int HOURS_W = 8
) (
    input  logic [HOURS_W-1:0] hours_i,
    output band_t              band_o
);

    localparam int EXT_W = (HOURS_W > BAND_W) ? HOURS_W : BAND_W;

    logic [EXT_W-1:0] hours_ext;

    // Widen the age, then clamp it to the last band.
    always_comb begin
        hours_ext = EXT_W'(hours_i);
        if (hours_ext > EXT_W'(LAST_BAND))
            band_o = band_t'(LAST_BAND);
        else
            band_o = hours_ext[BAND_W-1:0];
    end

endmodule

// File: rtl/lc_width_lut.sv
// Module: looks up the pulse width for a band index.
// Assumes: the band index is already clamped to the valid range.
module lc_width_lut
    import life_comp_pkg::*;
(
    input  band_t  band_i,
    output width_t width_o
);

    // Combinational schedule lookup.
    always_comb width_o = band_width(band_i);

endmodule

// File: rtl/lc_prescaler.sv
// Module: produces a one-clock count enable every TICK_DIV clocks.
// Assumes: TICK_DIV >= 1; with TICK_DIV == 1 the enable is always high.
module lc_prescaler #(
    parameter int TICK_DIV = 4096
) (
    input  logic clk_i,
    input  logic rst_n_i,
    output logic tick_o
);

    localparam int DIV_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(TICK_DIV - 1);

    logic [DIV_W-1:0] div_q;

    assign tick_o = (div_q == DIV_LAST);

    // Free-running divider, wraps when the enable fires.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i)
            div_q <= '0;
        else if (tick_o)
            div_q <= '0;
        else
            div_q <= div_q + 1'b1;
    end

endmodule

// File: rtl/lc_pwm_core.sv
// Module: PWM period counter and comparator with a registered output.
// Assumes: the next width is stable enough to be taken at any period wrap;
// the active width is only replaced at the wrap.
module lc_pwm_core
    import life_comp_pkg::*;
#(
    parameter int PERIOD = 255
) (
    input  logic   clk_i,
    input  logic   rst_n_i,
    input  logic   tick_i,
    input  width_t next_width_i,
    output logic [$clog2(PERIOD)-1:0] cnt_o,
    output width_t width_o,
    output logic   pwm_o
);

    localparam int CNT_W = $clog2(PERIOD);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PERIOD - 1);

    logic [CNT_W-1:0] cnt_q;
    width_t           width_q;
    logic             pwm_q;
    logic             wrap;

    assign wrap = tick_i && (cnt_q == CNT_LAST);

    // Period counter: advance on each enable, wrap after the last count.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i)
            cnt_q <= '0;
        else if (wrap)
            cnt_q <= '0;
        else if (tick_i)
            cnt_q <= cnt_q + 1'b1;
    end

    // Active width: band 0 at reset, refreshed only at the period wrap.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i)
            width_q <= band_width('0);
        else if (wrap)
            width_q <= next_width_i;
    end

    // Registered compare output, held low in reset.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i)
            pwm_q <= 1'b0;
        else
            pwm_q <= (WIDTH_W'(cnt_q) < width_q);
    end

    assign cnt_o   = cnt_q;
    assign width_o = width_q;
    assign pwm_o   = pwm_q;

endmodule

// File: rtl/life_comp_pwm.sv
// Module: top of the lifetime compensation PWM scheduler. Converts a lamp
// age in hundreds of hours into a stepped-down PWM duty for a driver's
// compensation input. Assumes the age input is synchronous to clk_i.
module life_comp_pwm
    import life_comp_pkg::*;
#(
    parameter int HOURS_W  = 8,
    parameter int TICK_DIV = 4096,
    parameter int PERIOD   = 255
) (
    input  logic               clk_i,
    input  logic               rst_n_i,
    input  logic [HOURS_W-1:0] life_hundreds_i,
    output logic               pwm_o
);

    localparam int CNT_W = $clog2(PERIOD);

    band_t            band;
    width_t           next_width;
    width_t           width_q;
    logic [CNT_W-1:0] cnt_q;
    logic             tick;

    lc_band_select #(.HOURS_W(HOURS_W)) band_i (
        .hours_i (life_hundreds_i),
        .band_o  (band)
    );

    lc_width_lut lut_i (
        .band_i  (band),
        .width_o (next_width)
    );

    lc_prescaler #(.TICK_DIV(TICK_DIV)) pre_i (
        .clk_i   (clk_i),
        .rst_n_i (rst_n_i),
        .tick_o  (tick)
    );

    lc_pwm_core #(.PERIOD(PERIOD)) core_i (
        .clk_i        (clk_i),
        .rst_n_i      (rst_n_i),
        .tick_i       (tick),
        .next_width_i (next_width),
        .cnt_o        (cnt_q),
        .width_o      (width_q),
        .pwm_o        (pwm_o)
    );

endmodule

// File: rtl/life_comp_pwm_chk.sv
// Module: assertion checker bound to life_comp_pwm.
module life_comp_pwm_chk #(
    parameter int HOURS_W = 8,
    parameter int PERIOD  = 255
) (
    input logic                       clk_i,
    input logic                       rst_n_i,
    input logic [HOURS_W-1:0]         hours_i,
    input logic                       pwm_i,
    input logic                       tick_i,
    input logic [$clog2(PERIOD)-1:0]  cnt_i,
    input logic [7:0]                 width_i
);

    localparam int CNT_W = $clog2(PERIOD);

    // R6: output was held low by reset on the first cycle after release.
    p_reset_low_r6: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        $rose(rst_n_i) |-> !pwm_i);

    // R6: band 0 width is active right after reset.
    p_reset_width_r6: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        $rose(rst_n_i) |-> (width_i == 8'd115));

    // R1: count never leaves 0..PERIOD-1.
    p_cnt_bound_r1: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        int'(cnt_i) < PERIOD);

    // R5: width holds unless a period wrap happens.
    p_width_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        !(tick_i && cnt_i == CNT_W'(PERIOD - 1)) |=> $stable(width_i));

    // R3: an age of ten hundreds or more loads the final width at a wrap.
    p_saturate_r3: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (tick_i && cnt_i == CNT_W'(PERIOD - 1) && int'(hours_i) >= 10)
        |=> (width_i == 8'd38));

endmodule

bind life_comp_pwm life_comp_pwm_chk #(.HOURS_W(HOURS_W), .PERIOD(PERIOD)) chk_i (
    .clk_i   (clk_i),
    .rst_n_i (rst_n_i),
    .hours_i (life_hundreds_i),
    .pwm_i   (pwm_o),
    .tick_i  (tick),
    .cnt_i   (cnt_q),
    .width_i (width_q)
);

// File: tb/life_comp_pwm_tb.sv
module life_comp_pwm_tb_top;

    localparam int HW  = 5;
    localparam int NV  = 13;
    localparam int PER = 255;
    localparam int VEC_H [NV] = '{0, 1, 2, 3, 4, 5, 6, 7, 8, 9, 10, 13, 31};
    localparam int VEC_W [NV] = '{115, 108, 100, 92, 85, 77, 69, 61, 54, 46, 38, 38, 38};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [HW-1:0] hours = '0;
    logic          pwm;
    logic          pwm3;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    life_comp_pwm #(.HOURS_W(HW), .TICK_DIV(1)) dut_i (
        .clk_i (clk), .rst_n_i (rst_n), .life_hundreds_i (hours), .pwm_o (pwm)
    );

    life_comp_pwm #(.HOURS_W(HW), .TICK_DIV(3)) dut_div_i (
        .clk_i (clk), .rst_n_i (rst_n), .life_hundreds_i (hours), .pwm_o (pwm3)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic pick(input int sel);
        return (sel == 0) ? pwm : pwm3;
    endfunction

    // Waits until the selected output rises (sampled on falling edges).
    task automatic wait_rise(input int sel);
        logic prev;
        prev = pick(sel);
        forever begin
            @(negedge clk);
            if (!prev && pick(sel)) break;
            prev = pick(sel);
        end
    endtask

    // Counts high samples over len samples starting at the current one.
    task automatic count_high(input int sel, input int len, output int hi);
        hi = int'(pick(sel));
        for (int i = 1; i < len; i++) begin
            @(negedge clk);
            hi += int'(pick(sel));
        end
    endtask

    initial begin
        #750us;
        fails++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int hi;
        int prev_w;
        int plen;
        // R6: output low while reset is held, age input nonzero.
        hours = 5'd7;
        repeat (6) @(negedge clk);
        check("R6 low in reset", int'(pwm), 0);
        rst_n = 1'b1;
        // R6: first period after reset uses band 0 width.
        wait_rise(0);
        count_high(0, PER, hi);
        check("R6 first period width", hi, 115);
        // R5: the age 7 width arrives at the next period.
        wait_rise(0);
        count_high(0, PER, hi);
        check("R5 next period width", hi, 61);

        // R1 R2 R3: table walk.
        prev_w = 256;
        for (int v = 0; v < NV; v++) begin
            hours = HW'(VEC_H[v]);
            wait_rise(0);
            wait_rise(0);
            count_high(0, PER, hi);
            check($sformatf("R2 R3 R1 age %0d", VEC_H[v]), hi, VEC_W[v]);
            if (v <= 10) begin
                // R4: strictly smaller than the previous band.
                check($sformatf("R4 decreasing band %0d", v), int'(hi < prev_w), 1);
                prev_w = hi;
            end
        end

        // R7: divided copy, width 38 at age 31.
        wait_rise(1);
        count_high(1, 3 * PER, hi);
        check("R7 divided high time", hi, 3 * 38);
        wait_rise(1);
        plen = 0;
        begin
            logic prev;
            prev = pwm3;
            forever begin
                @(negedge clk);
                plen++;
                if (!prev && pwm3) break;
                prev = pwm3;
            end
        end
        check("R7 divided period length", plen, 3 * PER);

        // R5: mid-period age change does not alter the running period.
        hours = 5'd2;
        wait_rise(0);
        wait_rise(0);
        hours = 5'd8;
        count_high(0, PER, hi);
        check("R5 period in progress keeps width", hi, 100);
        wait_rise(0);
        count_high(0, PER, hi);
        check("R5 new width after wrap", hi, 54);

        // R6: reset in mid-run drives output low and restores band 0.
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R6 low in mid-run reset", int'(pwm), 0);
        rst_n = 1'b1;
        wait_rise(0);
        count_high(0, PER, hi);
        check("R6 band 0 after mid-run reset", hi, 115);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule